// File: doc/BRIEF.md
# Link Negotiation and Keep-Alive Responder

This block sits behind a serial packet framer on the controller side of a host link. Framed bytes arrive one per cycle with an end-of-packet marker. The block checks link-management traffic as it streams past. That traffic is a fixed negotiation request, a keep-alive probe and the vendor firmware-download command. For each of these it emits a fixed-format reply, one byte per cycle, toward the transmit queue. From a firmware-download command that carries an address record it pulls a 48-bit device address, which is stored in a scrambled byte order.

Ordinary command, asynchronous-data and synchronous-data packets are not answered. They are passed out unchanged on a forwarding port. The block also owns the two control pins. It comes up when both pins become high together, and a falling edge on the reset pin shuts it down and clears its state. Packets are expected to arrive with their bytes in consecutive cycles.

Top module: `link_mgmt_responder`

## Requirements
- R1: After `rst_n` the block is disabled (`link_en`=0, no outputs, `dev_addr`=0). It becomes enabled on the cycle after `en_pin` and `rst_pin` are both sampled high, when they were not both high one cycle earlier. While it is disabled, input bytes are ignored entirely.
- R2: The 12-byte request `06 0A 00 A0 01 00 00 4C 00 96 00 00` is answered with `06 0A 20` and then its bytes 3..9 in order (`A0 01 00 00 4C 00 96`), followed by `FF FF`.
- R3: A type-6 packet that differs from that request in any byte or in its length gets no reply, and `err` pulses for one cycle.
- R4: A type-7 packet of exactly 4 bytes with `55` at byte 2 and `00` at byte 3 (byte 1 is free) is answered with `07 02 CC 00`. Any other type-7 packet gets no reply and pulses `err`.
- R5: An event packet (type 4), and any type byte other than 1, 2, 3, 6 or 7, gets no reply, is not forwarded, and pulses `err`.
- R6: A type-1 packet whose opcode is vendor group with sub-code 0 is answered with the 14 bytes `04 FF 0B` followed by eleven `00`. The opcode is byte 1 (low) and byte 2 (high); the group is byte2[7:2]=`3F` and the sub-code is {byte2[1:0], byte1}.
- R7: Such a command that is at least 30 bytes long, with `01` at byte 16 and `00` at byte 17, pulses `addr_upd` and loads `dev_addr`. The bytes go in order from least to most significant: packet bytes 29, 28, 26, 22, 25, 24. In any other case `dev_addr` is left unchanged.
- R8: A vendor-group command with a non-zero sub-code gets no reply and pulses `err`.
- R9: Packets of type 2 or 3, and type-1 packets that are not vendor group (including those shorter than 3 bytes), appear unchanged on the forwarding port. Each byte appears 3 cycles after it was taken, and `fwd_last` marks the final byte. Nothing else is forwarded.
- R10: A falling edge on `rst_pin` disables the block, aborts any reply in progress and clears `dev_addr` on the next cycle.
- R11: A reply that falls due while another reply is still on `tx_valid` (including the cycle of its final byte) is dropped, and `err` pulses.
- R12: A reply starts the cycle after the final request byte is taken. It is sent in consecutive cycles, and `tx_last` is high on its final byte only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pin | input | 1 | Enable control pin |
| rst_pin | input | 1 | Reset control pin, low holds the block off |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Final byte of the packet |
| tx_valid | output | 1 | Reply byte valid |
| tx_data | output | 8 | Reply byte |
| tx_last | output | 1 | Final reply byte |
| fwd_valid | output | 1 | Forwarded byte valid |
| fwd_data | output | 8 | Forwarded byte |
| fwd_last | output | 1 | Final forwarded byte |
| err | output | 1 | One-cycle pulse on a rejected packet or a dropped reply |
| addr_upd | output | 1 | One-cycle pulse when `dev_addr` is loaded |
| dev_addr | output | 48 | Captured device address |
| link_en | output | 1 | Block enabled |

## Verification
The bench goes after length boundaries: negotiation requests of 11 and 13 bytes, and address commands of 29 against 30 bytes. A design that compared only contents would answer a truncated request, and an off-by-one length test would capture or skip the address wrongly. Address captures are checked against the scrambled byte order with random payloads, which catches any swapped or shifted byte lane. Short type-1 packets and random non-vendor opcodes test the three-byte lookahead on the forwarding path: a wrong decision drops or leaks a packet. Back-to-back keep-alives and a reset-pin fall in mid-reply show whether a busy reply is protected and whether shutdown really aborts it.

// File: rtl/link_mgmt_responder.sv
module link_mgmt_responder #(
  parameter int IDX_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_pin,
  input  logic        rst_pin,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  output logic        fwd_valid,
  output logic [7:0]  fwd_data,
  output logic        fwd_last,
  output logic        err,
  output logic        addr_upd,
  output logic [47:0] dev_addr,
  output logic        link_en
);
  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};
  localparam logic [1:0] K_NEG = 2'd0, K_KA = 2'd1, K_VND = 2'd2;

  function automatic logic [7:0] neg_req(input logic [IDX_W-1:0] i);
    case (i)
      0: neg_req = 8'h06;  1: neg_req = 8'h0A;  3: neg_req = 8'hA0;
      4: neg_req = 8'h01;  7: neg_req = 8'h4C;  9: neg_req = 8'h96;
      default: neg_req = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] reply_byte(input logic [1:0] k, input logic [3:0] i);
    reply_byte = 8'h00;
    case (k)
      K_NEG: case (i)
        0: reply_byte = 8'h06;  1: reply_byte = 8'h0A;  2: reply_byte = 8'h20;
        3: reply_byte = 8'hA0;  4: reply_byte = 8'h01;  7: reply_byte = 8'h4C;
        9: reply_byte = 8'h96;  10, 11: reply_byte = 8'hFF;
        default: reply_byte = 8'h00;
      endcase
      K_KA: case (i)
        0: reply_byte = 8'h07;  1: reply_byte = 8'h02;  2: reply_byte = 8'hCC;
        default: reply_byte = 8'h00;
      endcase
      default: case (i)
        0: reply_byte = 8'h04;  1: reply_byte = 8'hFF;  2: reply_byte = 8'h0B;
        default: reply_byte = 8'h00;
      endcase
    endcase
  endfunction

  logic [1:0] pins_q;
  wire fall = pins_q[1] & ~rst_pin;
  wire rise = en_pin & rst_pin & (pins_q != 2'b11);
  wire acc  = in_valid & link_en;
  wire done = acc & in_last;

  logic [IDX_W-1:0] idx;
  logic [7:0]  typ, b1;
  logic        neg_ok, ka_ok, is_v, ocf0, mk;
  logic [47:0] atmp, atmp_n;
  wire sop = (idx == '0);

  wire [7:0] ty = sop ? in_data : typ;
  wire neg_n = (sop | neg_ok) & (idx < IDX_W'(12)) & (in_data == neg_req(idx));
  wire ka_n  = (sop | ka_ok) & ((idx == IDX_W'(0)) ? (in_data == 8'h07) :
                                (idx == IDX_W'(2)) ? (in_data == 8'h55) :
                                (idx == IDX_W'(3)) ? (in_data == 8'h00) : 1'b1);
  wire v_n   = (idx == IDX_W'(2)) ? (typ == 8'h01 && in_data[7:2] == 6'h3F) : (~sop & is_v);
  wire o_n   = (idx == IDX_W'(2)) ? ({in_data[1:0], b1} == 10'd0) : ocf0;
  wire mk_n  = (idx == IDX_W'(16)) ? (in_data == 8'h01) :
               (idx == IDX_W'(17)) ? (mk & (in_data == 8'h00)) : (~sop & mk);
  wire cap   = done & (ty == 8'h01) & v_n & o_n & mk_n & (idx >= IDX_W'(29));

  always_comb begin
    atmp_n = atmp;
    case (idx)
      29: atmp_n[7:0]   = in_data;
      28: atmp_n[15:8]  = in_data;
      26: atmp_n[23:16] = in_data;
      22: atmp_n[31:24] = in_data;
      25: atmp_n[39:32] = in_data;
      24: atmp_n[47:40] = in_data;
      default: ;
    endcase
  end

  logic       want, bad;
  logic [1:0] kind_n;
  always_comb begin
    want = 1'b0; bad = 1'b0; kind_n = K_KA;
    case (ty)
      8'h06: if (neg_n && idx == IDX_W'(11)) begin want = 1'b1; kind_n = K_NEG; end else bad = 1'b1;
      8'h07: if (ka_n && idx == IDX_W'(3)) want = 1'b1; else bad = 1'b1;
      8'h01: if (v_n) begin
               if (o_n) begin want = 1'b1; kind_n = K_VND; end else bad = 1'b1;
             end
      8'h02, 8'h03: ;
      default: bad = 1'b1;
    endcase
  end

  logic       tx_act;
  logic [1:0] kind;
  logic [3:0] tx_i;
  wire [3:0] last_i = (kind == K_NEG) ? 4'd11 : (kind == K_KA) ? 4'd3 : 4'd13;
  assign tx_valid = tx_act;
  assign tx_last  = tx_act & (tx_i == last_i);
  assign tx_data  = reply_byte(kind, tx_i);

  logic       s1v, s1l, s1s, s2v, s2l, s2s, dec;
  logic [7:0] s1d, s2d;
  wire b2_here = s2s & ~s2l & s1v & ~s1l & acc;
  wire vend0   = (s2d == 8'h01) & b2_here & (in_data[7:2] == 6'h3F);
  wire ok0     = (s2d == 8'h02) | (s2d == 8'h03) | ((s2d == 8'h01) & ~vend0);
  wire fwd_ok  = s2s ? ok0 : dec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q <= '0; link_en <= 1'b0; idx <= '0; typ <= '0; b1 <= '0;
      neg_ok <= 1'b0; ka_ok <= 1'b0; is_v <= 1'b0; ocf0 <= 1'b0; mk <= 1'b0;
      atmp <= '0; dev_addr <= '0; addr_upd <= 1'b0; err <= 1'b0;
      tx_act <= 1'b0; tx_i <= '0; kind <= K_KA;
      s1v <= 1'b0; s1l <= 1'b0; s1s <= 1'b0; s1d <= '0;
      s2v <= 1'b0; s2l <= 1'b0; s2s <= 1'b0; s2d <= '0; dec <= 1'b0;
      fwd_valid <= 1'b0; fwd_data <= '0; fwd_last <= 1'b0;
    end else begin
      pins_q <= {rst_pin, en_pin};
      if (fall) begin
        link_en <= 1'b0; idx <= '0; dev_addr <= '0; addr_upd <= 1'b0; err <= 1'b0;
        tx_act <= 1'b0; s1v <= 1'b0; s2v <= 1'b0; fwd_valid <= 1'b0; fwd_last <= 1'b0;
      end else begin
        if (rise) link_en <= 1'b1;
        if (acc) begin
          idx <= in_last ? '0 : (idx == IDX_MAX) ? idx : idx + 1'b1;
          typ <= ty;
          if (idx == IDX_W'(1)) b1 <= in_data;
          neg_ok <= neg_n; ka_ok <= ka_n; is_v <= v_n; ocf0 <= o_n; mk <= mk_n;
          atmp <= atmp_n;
        end
        err      <= done & (bad | (want & tx_act));
        addr_upd <= cap;
        if (cap) dev_addr <= atmp_n;
        if (tx_act) begin
          if (tx_i == last_i) tx_act <= 1'b0;
          else tx_i <= tx_i + 4'd1;
        end else if (done & want) begin
          tx_act <= 1'b1; tx_i <= '0; kind <= kind_n;
        end
        s1v <= acc; s1d <= in_data; s1l <= in_last; s1s <= sop;
        s2v <= s1v; s2d <= s1d; s2l <= s1l; s2s <= s1s;
        if (s2v & s2s) dec <= ok0;
        fwd_valid <= s2v & fwd_ok;
        fwd_data  <= s2d;
        fwd_last  <= s2v & fwd_ok & s2l;
      end
    end
  end
endmodule

// File: rtl/link_mgmt_responder_chk.sv
module link_mgmt_responder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en_pin,
  input logic        rst_pin,
  input logic        tx_valid,
  input logic [7:0]  tx_data,
  input logic        tx_last,
  input logic        err,
  input logic        addr_upd,
  input logic [47:0] dev_addr,
  input logic        link_en
);
  p_enable_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_en) |-> $past(en_pin) && $past(rst_pin));
  p_err_needs_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (err || addr_upd) |-> $past(link_en));
  p_addr_only_on_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dev_addr) |-> addr_upd || !link_en);
  p_fall_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_pin) && !rst_pin |=> !link_en && !tx_valid && dev_addr == 48'd0);
  p_reply_contiguous_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_last |=> tx_valid || !rst_pin);
  p_last_in_reply_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);
  p_reply_head_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> tx_data == 8'h06 || tx_data == 8'h07 || tx_data == 8'h04);
endmodule

bind link_mgmt_responder link_mgmt_responder_chk u_chk (.*);

// File: tb/sim_link_mgmt_responder.sv
module sim_link_mgmt_responder;
  typedef logic [7:0] bq_t[$];

  logic clk = 1'b0, rst_n = 1'b0, en_pin = 1'b0, rst_pin = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic tx_valid, tx_last, fwd_valid, fwd_last, err, addr_upd, link_en;
  logic [7:0] tx_data, fwd_data;
  logic [47:0] dev_addr;

  link_mgmt_responder u0 (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, errs = 0, upds = 0, t0 = 0, tf = -1;
  bit done = 0;
  bq_t txq, fwq;
  bit txl[$], fwl[$];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (tx_valid) begin txq.push_back(tx_data); txl.push_back(tx_last); end
    if (fwd_valid) begin
      if (fwq.size() == 0) tf = cyc;
      fwq.push_back(fwd_data); fwl.push_back(fwd_last);
    end
    if (err) errs++;
    if (addr_upd) upds++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clr();
    txq.delete(); txl.delete(); fwq.delete(); fwl.delete();
    errs = 0; upds = 0; tf = -1;
  endtask

  task automatic send(input bq_t p);
    for (int i = 0; i < p.size(); i++) begin
      @(negedge clk);
      if (i == 0) t0 = cyc;
      in_valid = 1'b1; in_data = p[i]; in_last = (i == p.size() - 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic send2(input bq_t a, input bq_t b);
    for (int i = 0; i < a.size() + b.size(); i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = (i < a.size()) ? a[i] : b[i - a.size()];
      in_last  = (i == a.size() - 1) || (i == a.size() + b.size() - 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bq_t neg_req();
    bq_t q = '{8'h06, 8'h0A, 8'h00, 8'hA0, 8'h01, 8'h00, 8'h00, 8'h4C, 8'h00, 8'h96, 8'h00, 8'h00};
    return q;
  endfunction

  function automatic bq_t neg_rep();
    bq_t r, q = neg_req();
    r = '{8'h06, 8'h0A, 8'h20};
    for (int i = 3; i <= 9; i++) r.push_back(q[i]);
    r.push_back(8'hFF); r.push_back(8'hFF);
    return r;
  endfunction

  function automatic bq_t ka_rep();
    bq_t r = '{8'h07, 8'h02, 8'hCC, 8'h00};
    return r;
  endfunction

  function automatic bq_t vnd_rep();
    bq_t r = '{8'h04, 8'hFF, 8'h0B};
    for (int i = 0; i < 11; i++) r.push_back(8'h00);
    return r;
  endfunction

  function automatic bq_t vnd_cmd(input int len, input bit mark);
    bq_t p = '{8'h01, 8'h00, 8'hFC};
    for (int i = 3; i < len; i++) p.push_back(8'($urandom));
    if (len > 17) begin
      p[16] = mark ? 8'h01 : 8'h02; p[17] = 8'h00;
    end
    return p;
  endfunction

  function automatic logic [47:0] addr_of(input bq_t p);
    return {p[24], p[25], p[22], p[26], p[28], p[29]};
  endfunction

  task automatic chk_reply(input bq_t exp, input string req);
    chk(txq.size() == exp.size(), req, "reply length", txq.size(), exp.size());
    if (txq.size() == exp.size()) begin
      bit ok = 1;
      int bi = 0;
      for (int i = 0; i < exp.size(); i++) begin
        if (txq[i] !== exp[i] || txl[i] !== (i == exp.size() - 1)) begin
          if (ok) bi = i;
          ok = 0;
        end
      end
      if (exp.size() > 0)
        chk(ok, req, $sformatf("reply byte/last at %0d", bi), {txl[bi], txq[bi]},
            {(bi == exp.size() - 1), exp[bi]});
    end
  endtask

  task automatic chk_fwd(input bq_t exp, input string req);
    chk(fwq.size() == exp.size(), req, "forward length", fwq.size(), exp.size());
    if (fwq.size() == exp.size()) begin
      bit ok = 1;
      for (int i = 0; i < exp.size(); i++)
        if (fwq[i] !== exp[i] || fwl[i] !== (i == exp.size() - 1)) ok = 0;
      if (exp.size() > 0) chk(ok, req, "forward bytes", fwq.size(), exp.size());
    end
  endtask

  initial begin
    bq_t p, q, none;
    logic [47:0] cur;
    void'($urandom(32'd7351));
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk(!link_en && !tx_valid && !fwd_valid && !err, "R1", "outputs after reset",
        {link_en, tx_valid, fwd_valid, err}, 0);
    chk(dev_addr == 0, "R1", "address after reset", dev_addr, 0);
    // R1 ignored while disabled
    clr(); send('{8'h07, 8'h00, 8'h55, 8'h00}); send('{8'h02, 8'h11, 8'h22}); idle(20);
    chk(txq.size() == 0 && fwq.size() == 0 && errs == 0, "R1", "traffic while disabled",
        txq.size() + fwq.size() + errs, 0);
    en_pin = 1'b1; rst_pin = 1'b1; idle(2);
    chk(link_en, "R1", "enable after both pins high", link_en, 1);

    // R2 / R12 negotiation
    clr(); send(neg_req()); idle(20);
    chk_reply(neg_rep(), "R2"); chk(errs == 0, "R2", "err on good request", errs, 0);

    // R3 corrupted and mis-sized requests
    for (int k = 0; k < 8; k++) begin
      p = neg_req();
      p[1 + ($urandom % 11)] ^= 8'(1 + ($urandom % 255));
      clr(); send(p); idle(20);
      chk(txq.size() == 0 && errs == 1, "R3", "corrupted request", {txq.size(), errs}, 1);
    end
    p = neg_req(); void'(p.pop_back());
    clr(); send(p); idle(20);
    chk(txq.size() == 0 && errs == 1, "R3", "11-byte request", {txq.size(), errs}, 1);
    p = neg_req(); p.push_back(8'h00);
    clr(); send(p); idle(20);
    chk(txq.size() == 0 && errs == 1, "R3", "13-byte request", {txq.size(), errs}, 1);

    // R4 keep-alive
    for (int k = 0; k < 4; k++) begin
      clr(); send('{8'h07, 8'($urandom), 8'h55, 8'h00}); idle(20);
      chk_reply(ka_rep(), "R4"); chk(errs == 0, "R4", "err on good probe", errs, 0);
    end
    clr(); send('{8'h07, 8'h00, 8'h56, 8'h00}); idle(20);
    chk(txq.size() == 0 && errs == 1, "R4", "bad probe byte", {txq.size(), errs}, 1);
    clr(); send('{8'h07, 8'h00, 8'h55, 8'h00, 8'h00}); idle(20);
    chk(txq.size() == 0 && errs == 1, "R4", "5-byte probe", {txq.size(), errs}, 1);

    // R5 event and unknown types
    clr(); send('{8'h04, 8'h0E, 8'h01, 8'h00}); idle(20);
    chk(txq.size() == 0 && fwq.size() == 0 && errs == 1, "R5", "event packet",
        {txq.size(), fwq.size(), errs}, 1);
    clr(); send('{8'h09, 8'h01, 8'h02}); idle(20);
    chk(txq.size() == 0 && fwq.size() == 0 && errs == 1, "R5", "unknown type",
        {txq.size(), fwq.size(), errs}, 1);

    // R6 vendor command, short, no capture
    cur = dev_addr;
    clr(); send(vnd_cmd(10, 1)); idle(20);
    chk_reply(vnd_rep(), "R6");
    chk(upds == 0 && dev_addr == cur && fwq.size() == 0, "R6", "short vendor: no capture/forward",
        {upds, fwq.size()}, 0);

    // R7 address capture
    for (int k = 0; k < 6; k++) begin
      p = vnd_cmd(30 + ($urandom % 10), 1);
      clr(); send(p); idle(20);
      chk_reply(vnd_rep(), "R7");
      chk(upds == 1 && dev_addr == addr_of(p), "R7", "captured address", dev_addr, addr_of(p));
    end
    cur = dev_addr;
    p = vnd_cmd(29, 1);
    clr(); send(p); idle(20);
    chk(upds == 0 && dev_addr == cur, "R7", "29-byte command keeps address", dev_addr, cur);
    p = vnd_cmd(34, 0);
    clr(); send(p); idle(20);
    chk(upds == 0 && dev_addr == cur, "R7", "wrong marker keeps address", dev_addr, cur);

    // R8 vendor with other sub-code
    clr(); send('{8'h01, 8'h01, 8'hFC, 8'h00}); idle(20);
    chk(txq.size() == 0 && errs == 1 && fwq.size() == 0, "R8", "sub-code 1",
        {txq.size(), errs, fwq.size()}, 1);
    clr(); send('{8'h01, 8'h00, 8'hFD, 8'h00}); idle(20);
    chk(txq.size() == 0 && errs == 1, "R8", "sub-code 0x100", {txq.size(), errs}, 1);

    // R9 forwarding
    for (int k = 0; k < 30; k++) begin
      int t = $urandom % 3;
      int len = 1 + ($urandom % 24);
      p = none;
      for (int i = 0; i < len; i++) p.push_back(8'($urandom));
      p[0] = (t == 0) ? 8'h02 : (t == 1) ? 8'h03 : 8'h01;
      if (t == 2 && len > 2 && p[2][7:2] == 6'h3F) p[2][7:2] = 6'h10;
      clr(); send(p); idle(20);
      chk_fwd(p, "R9");
      chk(txq.size() == 0 && errs == 0, "R9", "no reply/err on forwarded", {txq.size(), errs}, 0);
    end
    clr(); send('{8'h01, 8'h03}); idle(20);
    chk_fwd('{8'h01, 8'h03}, "R9");
    clr(); send('{8'h02, 8'h55, 8'hAA}); idle(20);
    chk(tf - t0 == 3, "R9", "forward latency", tf - t0, 3);

    // R11 busy drop
    clr(); send2('{8'h07, 8'h00, 8'h55, 8'h00}, '{8'h07, 8'h01, 8'h55, 8'h00}); idle(20);
    chk_reply(ka_rep(), "R11"); chk(errs == 1, "R11", "err on dropped reply", errs, 1);

    // R10 reset pin fall mid-reply
    chk(dev_addr != 0, "R10", "address present before fall", dev_addr, 1);
    clr(); send('{8'h07, 8'h00, 8'h55, 8'h00});
    rst_pin = 1'b0; idle(3);
    chk(txq.size() < 4, "R10", "reply aborted", txq.size(), 1);
    chk(!link_en && dev_addr == 0, "R10", "disabled and cleared", {link_en, dev_addr}, 0);
    clr(); send(neg_req()); idle(20);
    chk(txq.size() == 0, "R10", "no reply after fall", txq.size(), 0);
    rst_pin = 1'b1; idle(2);
    chk(link_en, "R1", "re-enable", link_en, 1);
    clr(); send('{8'h07, 8'h42, 8'h55, 8'h00}); idle(20);
    chk_reply(ka_rep(), "R10");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule